// File: doc/BRIEF.md
# Integer Execute Unit with Signed Shifts

This block is the integer datapath of a coprocessor that owns sixteen 64-bit registers. An instruction word arrives with a one-cycle valid strobe. The unit decodes it, reads up to three registers, computes the result and writes it back to the register file at the same clock edge. It also presents the written value on a registered write-back port during the following cycle. The operations are 32-bit and 64-bit add, subtract, negate, absolute value and multiply, plus 32-bit multiply-accumulate and multiply-subtract. Shifts are bidirectional: the sign of the amount picks the direction. The amount is either a 7-bit signed immediate spread over two instruction fields, or a 32-bit value supplied by the host core.

The host core places values in registers through a load port and reads any register through a combinational read port. A 32-bit operation uses only the low half of each source and replaces only the low half of its destination. All arithmetic wraps.

Top module: `int_exec_unit`

## Requirements
- R1: After reset every register reads zero and `wb_en_o` is low.
- R2: When `reg_shift_i` is 0, the operation group is instr[21:20], the sub-operation is instr[7:5], the destination is instr[15:12], the first source is instr[19:16] and the second source is instr[3:0]. In group 3, sub-operations 4 to 7 are add32, add64, sub32 and sub64; they wrap modulo 2^32 or 2^64. A 32-bit result replaces bits 31:0 of the destination and leaves bits 63:32 unchanged.
- R3: In group 3, sub-operations 0 to 3 are abs32, abs64, neg32 and neg64 of the first source, computed in two's complement. The absolute value of the most negative number is that number itself.
- R4: In group 1, sub-operation 0 stores the low 32 bits of the product of the two low halves (mul32), and sub-operation 1 stores the low 64 bits of the 64-bit product (mul64).
- R5: In group 1, sub-operations 2 and 3 add or subtract the 32-bit product of the two low halves to or from the low half of the old destination value (multiply-accumulate and multiply-subtract).
- R6: Groups 0 and 2 shift the first source: group 0 shifts its low 32 bits and group 2 shifts all 64. The amount is {instr[7:5], instr[3:0]}, sign-extended from bit 6. A positive amount shifts left. Any other amount shifts arithmetically right by its magnitude.
- R7: When `reg_shift_i` is 1, sub-operation 2 is a 32-bit shift and sub-operation 3 is a 64-bit shift. The source is instr[19:16], the destination is instr[3:0], and the amount is `host_val_i` as a signed number. A value above zero shifts left; otherwise the shift is arithmetic right by the negated value. A magnitude at or above the width gives zero for a left shift and sign fill for a right shift.
- R8: The result is written to the register file at the clock edge that samples `valid_i`, so the next instruction in the following cycle already sees it. `wb_en_o`, `wb_idx_o` and `wb_data_o` show the write in the cycle after that edge, and `wb_en_o` is low in any cycle that follows an edge without a valid instruction.
- R9: Encodings outside R2 to R7 write nothing and leave `wb_en_o` low. These are group 1 sub-operations 4 to 7, and `reg_shift_i` set with a sub-operation other than 2 or 3.
- R10: `ld_en_i` writes `ld_data_i` into register `ld_idx_i` at the clock edge. A load presented while `valid_i` is high is dropped. `rd_data_o` shows register `rd_idx_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction strobe, one cycle per instruction |
| instr_i | input | 32 | Instruction word |
| reg_shift_i | input | 1 | Selects the host-amount shift form |
| host_val_i | input | 32 | Shift amount from the host core |
| ld_en_i | input | 1 | Host load strobe |
| ld_idx_i | input | 4 | Register written by a load |
| ld_data_i | input | 64 | Value written by a load |
| rd_idx_i | input | 4 | Register shown on the read port |
| rd_data_o | output | 64 | Read port value |
| wb_en_o | output | 1 | Write-back happened at the last edge |
| wb_idx_o | output | 4 | Register written at the last edge |
| wb_data_o | output | 64 | Value written at the last edge |

## Verification
Every result takes effect at the first rising edge after the bench raises `valid_i`. Each issued instruction pushes one expected item into a scoreboard queue. The register-file contents are visible on the read port from that edge onward. The write-back port holds the result for the cycle after that edge. The monitor notes which edges sampled a valid instruction and pops the matching item at the next falling edge. Register read-backs are sampled at a falling edge after the bench has dropped `valid_i`. Back-to-back issues of dependent multiply-accumulates confirm that each result is ready one cycle later.

// File: rtl/xu_pkg.sv
package xu_pkg;
  localparam int XU_XW   = 64;
  localparam int XU_HW   = XU_XW / 2;
  localparam int XU_NREG = 16;
  localparam int XU_IDXW = $clog2(XU_NREG);
  localparam int XU_AMTW = 32;

  typedef enum logic [3:0] {
    OP_ADD32, OP_ADD64, OP_SUB32, OP_SUB64,
    OP_NEG32, OP_NEG64, OP_ABS32, OP_ABS64,
    OP_MUL32, OP_MUL64, OP_MAC32, OP_MSC32,
    OP_SH32,  OP_SH64
  } xu_op_e;

  typedef struct packed {
    logic                 legal;
    logic                 is32;
    xu_op_e               op;
    logic [XU_IDXW-1:0]   src1;
    logic [XU_IDXW-1:0]   src2;
    logic [XU_IDXW-1:0]   dst;
    logic [XU_AMTW-1:0]   shamt;
  } xu_ctrl_t;
endpackage

// File: rtl/xu_decoder.sv
module xu_decoder
  import xu_pkg::*;
#(
  parameter int AMTW = XU_AMTW
) (
  input  logic [31:0]     instr_i,
  input  logic            reg_shift_i,
  input  logic [AMTW-1:0] host_val_i,
  output xu_ctrl_t        ctrl_o
);
  localparam int IMMW = 7;

  logic [1:0]      grp;
  logic [2:0]      sub;
  logic [IMMW-1:0] imm;
  logic            unused_fields;

  assign grp = instr_i[21:20];
  assign sub = instr_i[7:5];
  assign imm = {instr_i[7:5], instr_i[3:0]};
  assign unused_fields = ^{instr_i[31:22], instr_i[11:8], instr_i[4]};

  always_comb begin
    ctrl_o       = '0;
    ctrl_o.op    = OP_ADD32;
    ctrl_o.src1  = instr_i[19:16];
    ctrl_o.src2  = instr_i[3:0];
    ctrl_o.dst   = instr_i[15:12];
    ctrl_o.shamt = {{(AMTW-IMMW){imm[IMMW-1]}}, imm};
    if (reg_shift_i) begin
      ctrl_o.dst   = instr_i[3:0];
      ctrl_o.shamt = host_val_i;
      case (sub)
        3'd2: begin ctrl_o.legal = 1'b1; ctrl_o.is32 = 1'b1; ctrl_o.op = OP_SH32; end
        3'd3: begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_SH64; end
        default: ctrl_o.legal = 1'b0;
      endcase
    end else begin
      case (grp)
        2'd0: begin ctrl_o.legal = 1'b1; ctrl_o.is32 = 1'b1; ctrl_o.op = OP_SH32; end
        2'd2: begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_SH64; end
        2'd1: begin
          case (sub)
            3'd0: begin ctrl_o.legal = 1'b1; ctrl_o.is32 = 1'b1; ctrl_o.op = OP_MUL32; end
            3'd1: begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_MUL64; end
            3'd2: begin ctrl_o.legal = 1'b1; ctrl_o.is32 = 1'b1; ctrl_o.op = OP_MAC32; end
            3'd3: begin ctrl_o.legal = 1'b1; ctrl_o.is32 = 1'b1; ctrl_o.op = OP_MSC32; end
            default: ctrl_o.legal = 1'b0;
          endcase
        end
        default: begin
          ctrl_o.legal = 1'b1;
          ctrl_o.is32  = ~sub[0];
          case (sub)
            3'd0: ctrl_o.op = OP_ABS32;
            3'd1: ctrl_o.op = OP_ABS64;
            3'd2: ctrl_o.op = OP_NEG32;
            3'd3: ctrl_o.op = OP_NEG64;
            3'd4: ctrl_o.op = OP_ADD32;
            3'd5: ctrl_o.op = OP_ADD64;
            3'd6: ctrl_o.op = OP_SUB32;
            default: ctrl_o.op = OP_SUB64;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/xu_shifter.sv
module xu_shifter #(
  parameter int W    = 32,
  parameter int AMTW = 32
) (
  input  logic [W-1:0]    x_i,
  input  logic [AMTW-1:0] amt_i,
  output logic [W-1:0]    y_o
);
  localparam int LW = $clog2(W);

  logic            go_left;
  logic [AMTW-1:0] mag;
  logic            too_far;

  always_comb begin
    go_left = $signed(amt_i) > 0;
    mag     = go_left ? amt_i : AMTW'(-amt_i);
    too_far = mag >= AMTW'(W);
    if (go_left)
      y_o = too_far ? '0 : (x_i << mag[LW-1:0]);
    else
      y_o = too_far ? {W{x_i[W-1]}} : W'($signed(x_i) >>> mag[LW-1:0]);
  end

  always_comb begin
    if (!$isunknown({x_i, amt_i})) begin
      if (amt_i == '0)
        assert_zero_amount_R7: assert (y_o == x_i);
      if ($signed(amt_i) >= W)
        assert_left_overrun_R7: assert (y_o == '0);
    end
  end
endmodule

// File: rtl/xu_alu.sv
module xu_alu
  import xu_pkg::*;
#(
  parameter int XW   = XU_XW,
  parameter int AMTW = XU_AMTW
) (
  input  xu_op_e          op_i,
  input  logic [XW-1:0]   a_i,
  input  logic [XW-1:0]   b_i,
  input  logic [XW-1:0]   d_i,
  input  logic [AMTW-1:0] amt_i,
  output logic [XW-1:0]   res_o
);
  localparam int HW = XW / 2;

  logic [HW-1:0] a_lo, b_lo, d_lo, prod32, r32, sh32_y;
  logic [XW-1:0] prod64, r64, sh64_y;
  logic          narrow;

  assign a_lo   = a_i[HW-1:0];
  assign b_lo   = b_i[HW-1:0];
  assign d_lo   = d_i[HW-1:0];
  assign prod32 = a_lo * b_lo;
  assign prod64 = a_i * b_i;

  xu_shifter #(.W(HW), .AMTW(AMTW)) u_sh32 (.x_i(a_lo), .amt_i(amt_i), .y_o(sh32_y));
  xu_shifter #(.W(XW), .AMTW(AMTW)) u_sh64 (.x_i(a_i),  .amt_i(amt_i), .y_o(sh64_y));

  always_comb begin
    r32    = '0;
    r64    = '0;
    narrow = 1'b1;
    case (op_i)
      OP_ADD32: r32 = a_lo + b_lo;
      OP_SUB32: r32 = a_lo - b_lo;
      OP_NEG32: r32 = -a_lo;
      OP_ABS32: r32 = a_lo[HW-1] ? -a_lo : a_lo;
      OP_MUL32: r32 = prod32;
      OP_MAC32: r32 = d_lo + prod32;
      OP_MSC32: r32 = d_lo - prod32;
      OP_SH32:  r32 = sh32_y;
      OP_ADD64: begin narrow = 1'b0; r64 = a_i + b_i; end
      OP_SUB64: begin narrow = 1'b0; r64 = a_i - b_i; end
      OP_NEG64: begin narrow = 1'b0; r64 = -a_i; end
      OP_ABS64: begin narrow = 1'b0; r64 = a_i[XW-1] ? -a_i : a_i; end
      OP_MUL64: begin narrow = 1'b0; r64 = prod64; end
      default:  begin narrow = 1'b0; r64 = sh64_y; end
    endcase
    res_o = narrow ? {d_i[XW-1:HW], r32} : r64;
  end

  always_comb begin
    if (!$isunknown({op_i, a_i})) begin
      if (op_i == OP_ABS32 && a_lo != {1'b1, {(HW-1){1'b0}}})
        assert_abs32_sign_R3: assert (!res_o[HW-1]);
      if (op_i == OP_ABS64 && a_i != {1'b1, {(XW-1){1'b0}}})
        assert_abs64_sign_R3: assert (!res_o[XW-1]);
    end
  end
endmodule

// File: rtl/xu_regfile.sv
module xu_regfile #(
  parameter int NREG = 16,
  parameter int XW   = 64,
  parameter int NRD  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_i,
  input  logic [$clog2(NREG)-1:0]       widx_i,
  input  logic [XW-1:0]                 wdata_i,
  input  logic [NRD-1:0][$clog2(NREG)-1:0] ridx_i,
  output logic [NRD-1:0][XW-1:0]        rdata_o
);
  localparam int AW = $clog2(NREG);

  logic [XW-1:0] mem_q [NREG];
  logic [XW-1:0] mem_d [NREG];

  always_comb begin
    for (int e = 0; e < NREG; e++)
      mem_d[e] = (we_i && widx_i == AW'(e)) ? wdata_i : mem_q[e];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NREG; e++) mem_q[e] <= '0;
    end else if (we_i) begin
      for (int e = 0; e < NREG; e++) mem_q[e] <= mem_d[e];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = mem_q[ridx_i[p]];
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import xu_pkg::*;
#(
  parameter int XW   = XU_XW,
  parameter int NREG = XU_NREG,
  parameter int AMTW = XU_AMTW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid_i,
  input  logic [31:0]              instr_i,
  input  logic                     reg_shift_i,
  input  logic [AMTW-1:0]          host_val_i,
  input  logic                     ld_en_i,
  input  logic [$clog2(NREG)-1:0]  ld_idx_i,
  input  logic [XW-1:0]            ld_data_i,
  input  logic [$clog2(NREG)-1:0]  rd_idx_i,
  output logic [XW-1:0]            rd_data_o,
  output logic                     wb_en_o,
  output logic [$clog2(NREG)-1:0]  wb_idx_o,
  output logic [XW-1:0]            wb_data_o
);
  localparam int AW  = $clog2(NREG);
  localparam int HW  = XW / 2;
  localparam int NRD = 4;

  xu_ctrl_t               ctrl;
  logic [NRD-1:0][AW-1:0] ridx;
  logic [NRD-1:0][XW-1:0] rdat;
  logic [XW-1:0]          alu_res;
  logic                   exec_we;
  logic                   rf_we;
  logic [AW-1:0]          rf_widx;
  logic [XW-1:0]          rf_wdata;

  logic                   wb_en_d, wb_en_q;
  logic [AW-1:0]          wb_idx_d, wb_idx_q;
  logic [XW-1:0]          wb_data_d, wb_data_q;

  xu_decoder #(.AMTW(AMTW)) u_dec (
    .instr_i(instr_i), .reg_shift_i(reg_shift_i),
    .host_val_i(host_val_i), .ctrl_o(ctrl)
  );

  assign ridx = {rd_idx_i, ctrl.dst, ctrl.src2, ctrl.src1};

  xu_regfile #(.NREG(NREG), .XW(XW), .NRD(NRD)) u_rf (
    .clk(clk), .rst_n(rst_n), .we_i(rf_we), .widx_i(rf_widx),
    .wdata_i(rf_wdata), .ridx_i(ridx), .rdata_o(rdat)
  );

  xu_alu #(.XW(XW), .AMTW(AMTW)) u_alu (
    .op_i(ctrl.op), .a_i(rdat[0]), .b_i(rdat[1]), .d_i(rdat[2]),
    .amt_i(ctrl.shamt), .res_o(alu_res)
  );

  assign exec_we  = valid_i & ctrl.legal;
  assign rf_we    = exec_we | (ld_en_i & ~valid_i);
  assign rf_widx  = exec_we ? ctrl.dst : ld_idx_i;
  assign rf_wdata = exec_we ? alu_res : ld_data_i;

  always_comb begin
    wb_en_d   = exec_we;
    wb_idx_d  = exec_we ? ctrl.dst : wb_idx_q;
    wb_data_d = exec_we ? alu_res  : wb_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en_q   <= 1'b0;
      wb_idx_q  <= '0;
      wb_data_q <= '0;
    end else begin
      wb_en_q   <= wb_en_d;
      wb_idx_q  <= wb_idx_d;
      wb_data_q <= wb_data_d;
    end
  end

  assign rd_data_o = rdat[3];
  assign wb_en_o   = wb_en_q;
  assign wb_idx_o  = wb_idx_q;
  assign wb_data_o = wb_data_q;

  assert_wb_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !wb_en_o);

  assert_wb_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ctrl.legal) |=> (wb_en_o && wb_idx_o == $past(ctrl.dst)));

  assert_upper_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ctrl.legal && ctrl.is32) |=> (wb_data_o[XW-1:HW] == $past(rdat[2][XW-1:HW])));

  assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !ctrl.legal) |=> !wb_en_o);
endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        en;
    logic [3:0]  idx;
    logic [63:0] data;
    logic [7:0]  rq;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        reg_shift_i = 1'b0;
  logic [31:0] host_val_i = '0;
  logic        ld_en_i = 1'b0;
  logic [3:0]  ld_idx_i = '0;
  logic [63:0] ld_data_i = '0;
  logic [3:0]  rd_idx_i = '0;
  logic [63:0] rd_data_o;
  logic        wb_en_o;
  logic [3:0]  wb_idx_o;
  logic [63:0] wb_data_o;

  int   n_chk = 0;
  int   n_err = 0;
  logic due = 1'b0;
  exp_t q[$];
  logic [63:0] mdl [16];

  always #(CLK_P/2) clk = ~clk;

  int_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .reg_shift_i(reg_shift_i), .host_val_i(host_val_i),
    .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
    .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o)
  );

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sh32f(input logic [31:0] x, input logic [31:0] amt);
    logic [31:0] m;
    if ($signed(amt) > 0) return (amt >= 32) ? 32'h0 : (x << amt);
    m = -amt;
    if (m >= 32) return {32{x[31]}};
    return 32'($signed(x) >>> m);
  endfunction

  function automatic logic [63:0] sh64f(input logic [63:0] x, input logic [31:0] amt);
    logic [31:0] m;
    if ($signed(amt) > 0) return (amt >= 64) ? 64'h0 : (x << amt);
    m = -amt;
    if (m >= 64) return {64{x[63]}};
    return 64'($signed(x) >>> m);
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] g, input logic [2:0] op,
                                     input logic [3:0] d, input logic [3:0] s1, input logic [3:0] s2);
    return {10'b0, g, s1, d, 4'b0, op, 1'b0, s2};
  endfunction

  function automatic logic [31:0] mkimm(input logic [1:0] g, input logic [3:0] d,
                                        input logic [3:0] s1, input logic [6:0] amt);
    return {10'b0, g, s1, d, 4'b0, amt[6:4], 1'b0, amt[3:0]};
  endfunction

  function automatic logic [31:0] mkreg(input logic [2:0] op, input logic [3:0] s1, input logic [3:0] d);
    return {12'b0, s1, 8'b0, op, 1'b0, d};
  endfunction

  // Reference model written from the requirements.
  task automatic model(input logic [31:0] ins, input logic rs, input logic [31:0] hv, output exp_t e);
    logic [63:0] a, b, d, r;
    logic [31:0] al, bl, dl, imm;
    logic [2:0]  op;
    a  = mdl[ins[19:16]];
    b  = mdl[ins[3:0]];
    al = a[31:0];
    bl = b[31:0];
    op = ins[7:5];
    imm = {{25{ins[7]}}, ins[7:5], ins[3:0]};
    e.en = 1'b1;
    e.rq = 8'd2;
    r = '0;
    if (rs) begin
      e.idx = ins[3:0];
      d = mdl[e.idx];
      e.rq = 8'd7;
      if (op == 3'd2)      r = {d[63:32], sh32f(al, hv)};
      else if (op == 3'd3) r = sh64f(a, hv);
      else begin e.en = 1'b0; e.rq = 8'd9; end
    end else begin
      e.idx = ins[15:12];
      d = mdl[e.idx];
      dl = d[31:0];
      case (ins[21:20])
        2'd0: begin e.rq = 8'd6; r = {d[63:32], sh32f(al, imm)}; end
        2'd2: begin e.rq = 8'd6; r = sh64f(a, imm); end
        2'd1: begin
          e.rq = 8'd4;
          case (op)
            3'd0: r = {d[63:32], 32'(al * bl)};
            3'd1: r = a * b;
            3'd2: begin e.rq = 8'd5; r = {d[63:32], 32'(dl + al * bl)}; end
            3'd3: begin e.rq = 8'd5; r = {d[63:32], 32'(dl - al * bl)}; end
            default: begin e.en = 1'b0; e.rq = 8'd9; end
          endcase
        end
        default: begin
          e.rq = (op < 3'd4) ? 8'd3 : 8'd2;
          case (op)
            3'd0: r = {d[63:32], al[31] ? -al : al};
            3'd1: r = a[63] ? -a : a;
            3'd2: r = {d[63:32], -al};
            3'd3: r = -a;
            3'd4: r = {d[63:32], al + bl};
            3'd5: r = a + b;
            3'd6: r = {d[63:32], al - bl};
            default: r = a - b;
          endcase
        end
      endcase
    end
    e.data = r;
  endtask

  task automatic issue(input logic [31:0] ins, input logic rs = 1'b0, input logic [31:0] hv = '0);
    exp_t e;
    model(ins, rs, hv, e);
    q.push_back(e);
    if (e.en) mdl[e.idx] = e.data;
    @(negedge clk);
    valid_i = 1'b1; instr_i = ins; reg_shift_i = rs; host_val_i = hv;
    ld_en_i = 1'b0;
  endtask

  task automatic load(input logic [3:0] idx, input logic [63:0] v);
    mdl[idx] = v;
    @(negedge clk);
    valid_i = 1'b0; ld_en_i = 1'b1; ld_idx_i = idx; ld_data_i = v;
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0; ld_en_i = 1'b0;
  endtask

  task automatic check_reg(input logic [3:0] idx, input int rq);
    @(negedge clk);
    rd_idx_i = idx;
    #1;
    chk(rd_data_o == mdl[idx], rq, $sformatf("register %0d", idx), rd_data_o, mdl[idx]);
  endtask

  // Scoreboard monitor: a valid sampled at an edge is due at the next falling edge.
  always @(posedge clk) due <= valid_i;

  always @(negedge clk) begin
    exp_t e;
    if (due) begin
      if (q.size() == 0) begin
        chk(1'b0, 8, "unexpected write-back", 64'(wb_en_o), 64'h0);
      end else begin
        e = q.pop_front();
        chk(wb_en_o == e.en, int'(e.rq), "wb_en", 64'(wb_en_o), 64'(e.en));
        if (e.en) begin
          chk(wb_idx_o == e.idx, int'(e.rq), "wb_idx", 64'(wb_idx_o), 64'(e.idx));
          chk(wb_data_o == e.data, int'(e.rq), "wb_data", wb_data_o, e.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL R8 watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    #1 chk(wb_en_o == 1'b0, 1, "wb_en after reset", 64'(wb_en_o), 64'h0);
    check_reg(4'd0, 1);
    check_reg(4'd15, 1);

    // R10: host loads and readback
    load(4'd1, 64'h0000_0001_FFFF_FFFF);
    load(4'd2, 64'h1234_5678_0000_0002);
    load(4'd3, 64'hAAAA_BBBB_CCCC_DDDD);
    load(4'd4, 64'h8000_0000_8000_0000);
    load(4'd5, 64'hFFFF_FFFF_FFFF_FFF0);
    load(4'd6, 64'h0000_0000_0000_0007);
    load(4'd7, 64'hF000_0000_8765_4321);
    idle();
    check_reg(4'd1, 10);
    check_reg(4'd7, 10);

    // R2: add/sub with wrap, upper half kept on 32-bit ops
    issue(mk(2'd3, 3'd4, 4'd3, 4'd1, 4'd2));
    issue(mk(2'd3, 3'd5, 4'd8, 4'd1, 4'd2));
    issue(mk(2'd3, 3'd6, 4'd9, 4'd6, 4'd5));
    issue(mk(2'd3, 3'd7, 4'd10, 4'd6, 4'd5));
    idle();
    check_reg(4'd3, 2);
    check_reg(4'd8, 2);

    // R3: abs/neg including most negative inputs
    issue(mk(2'd3, 3'd0, 4'd11, 4'd5, 4'd0));
    issue(mk(2'd3, 3'd0, 4'd12, 4'd4, 4'd0));
    issue(mk(2'd3, 3'd1, 4'd13, 4'd5, 4'd0));
    issue(mk(2'd3, 3'd2, 4'd14, 4'd7, 4'd0));
    issue(mk(2'd3, 3'd3, 4'd15, 4'd4, 4'd0));
    idle();
    check_reg(4'd12, 3);

    // R4, R5, R8: multiplies and dependent back-to-back accumulates
    issue(mk(2'd1, 3'd0, 4'd8, 4'd7, 4'd5));
    issue(mk(2'd1, 3'd1, 4'd9, 4'd7, 4'd6));
    issue(mk(2'd1, 3'd2, 4'd10, 4'd6, 4'd5));
    issue(mk(2'd1, 3'd2, 4'd10, 4'd6, 4'd6));
    issue(mk(2'd1, 3'd3, 4'd10, 4'd7, 4'd6));
    idle();
    check_reg(4'd10, 5);

    // R6: immediate shifts, both directions and extremes
    issue(mkimm(2'd0, 4'd11, 4'd7, 7'd5));
    issue(mkimm(2'd0, 4'd12, 4'd7, 7'h7D));
    issue(mkimm(2'd2, 4'd13, 4'd7, 7'h40));
    issue(mkimm(2'd2, 4'd14, 4'd6, 7'd63));
    issue(mkimm(2'd2, 4'd15, 4'd7, 7'h7F));
    idle();
    check_reg(4'd12, 6);

    // R7: host-amount shifts, zero amount and overrun
    issue(mkreg(3'd2, 4'd7, 4'd1), 1'b1, 32'd4);
    issue(mkreg(3'd2, 4'd7, 4'd2), 1'b1, -32'sd8);
    issue(mkreg(3'd3, 4'd7, 4'd3), 1'b1, 32'd0);
    issue(mkreg(3'd2, 4'd6, 4'd4), 1'b1, 32'd40);
    issue(mkreg(3'd3, 4'd7, 4'd5), 1'b1, -32'sd100);
    issue(mkreg(3'd3, 4'd5, 4'd6), 1'b1, 32'h8000_0000);
    issue(mkreg(3'd3, 4'd6, 4'd8), 1'b1, 32'd1);
    idle();
    check_reg(4'd0, 7);
    check_reg(4'd2, 7);

    // R9: unsupported encodings write nothing
    issue(mk(2'd1, 3'd5, 4'd9, 4'd7, 4'd6));
    issue(mkreg(3'd0, 4'd7, 4'd9), 1'b1, 32'd3);
    idle();
    check_reg(4'd9, 9);

    // R10: a load that coincides with valid is dropped
    begin
      exp_t e;
      logic [31:0] ins;
      ins = mk(2'd3, 3'd5, 4'd8, 4'd1, 4'd2);
      model(ins, 1'b0, 32'h0, e);
      q.push_back(e);
      mdl[e.idx] = e.data;
      @(negedge clk);
      valid_i = 1'b1; instr_i = ins; reg_shift_i = 1'b0; host_val_i = '0;
      ld_en_i = 1'b1; ld_idx_i = 4'd11; ld_data_i = 64'hDEAD_BEEF_0BAD_F00D;
    end
    idle();
    check_reg(4'd11, 10);
    check_reg(4'd8, 10);

    repeat (3) idle();
    chk(q.size() == 0, 8, "scoreboard drained", 64'(q.size()), 64'h0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule